// File: doc/BRIEF.md
# Receive Queue Transfer Port

This block sits between a serial-bus receiver and a host processor. The receiver delivers two streams of 32-bit quadlets: one for incoming requests and one for incoming responses. Each stream goes into its own small FIFO. Every quadlet carries an end-of-packet tag. Request quadlets also carry a self-ID tag. The head of each FIFO is moved into a read-only transfer register, and the host drains the queue one quadlet at a time by reading that register.

A single status word gives the host each queue's state: whether a quadlet is waiting, whether it ends a packet, whether it is self-ID data, whether the queue has ever filled, and whether a read fault has blocked the queue. Two clearing rules apply:

- The per-quadlet flags clear automatically when the quadlet is read.
- The sticky fault and full flags clear only when software writes 1 to them.

A bus reset throws away all buffered data and blocks both queues. Software must acknowledge the block before it can read again.

The host bus is a simple single-cycle port. During a read cycle, read data is valid combinationally from the current state. All side effects of the access take place on the clock edge that ends the cycle.

Top module: `rxq_xfer_port`

## Requirements
- R1: Word address 0 reads the request transfer register and address 1 reads the response transfer register. A successful read returns the quadlets of a queue in the order they were pushed.
- R2: A successful read clears that queue's available flag at the ending edge. When the FIFO holds another quadlet, that quadlet loads on the following edge and the flag sets again.
- R3: The last flag of a queue (status bit 12 for requests, bit 13 for responses) is set exactly while the loaded quadlet carries the end-of-packet tag. It is cleared by the read.
- R4: Status bit 14 is set while the loaded request quadlet was pushed with the self-ID tag inside the self-ID window. The window opens at reset and at bus reset, and it closes on the first request push without the tag.
- R5: A read of an unblocked queue with no quadlet available returns 0 and sets that queue's error flag (bit 10 for requests, bit 11 for responses). While the error flag is set, reads of that queue return 0 and neither consume nor change the loaded quadlet.
- R6: A queue's full flag (bit 15 for requests, bit 16 for responses) sets once its FIFO holds DEPTH entries. It stays set until a write of 1 to that bit at address 2.
- R7: A bus reset, in one cycle, flushes both FIFOs and the transfer registers, clears the available, last and self-ID flags, and sets both error flags.
- R8: The status word at address 2 reads 0x00000C00 after reset. Bit 8 is request available and bit 9 is response available. Bits 31..17 and 7..0 read 0.
- R9: A status write clears only the error and full bits whose written value is 1. Written zeros, and ones on bits 8, 9, 12, 13 and 14, have no effect.
- R10: A quadlet pushed while its FIFO already holds DEPTH entries is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | Serial-bus reset pulse |
| req_push | input | 1 | Push a quadlet into the request queue |
| req_data | input | DW | Request quadlet |
| req_last | input | 1 | Request quadlet ends a packet |
| req_sid | input | 1 | Request quadlet is self-ID data |
| rsp_push | input | 1 | Push a quadlet into the response queue |
| rsp_data | input | DW | Response quadlet |
| rsp_last | input | 1 | Response quadlet ends a packet |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Word address: 0 request, 1 response, 2 status |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Host read data |

## Verification
The assertions check several rules on every cycle:

- the read-to-empty step of the available flag and the refusal of a blocked read;
- the complete state left by a bus reset;
- the stickiness of the full flag;
- the pairing of the last flag with a loaded quadlet;
- the FIFO occupancy bound.

Other behaviour can only be shown by the bench's scenarios:

- quadlet ordering, including the drop of the tenth push into a full queue;
- the opening and closing of the self-ID window;
- the reset value of the status word;
- the write-0 and write-to-auto-bit cases;
- the flushing of queued data by a bus reset.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int QW = 32;

    typedef enum logic [1:0] {
        ADDR_REQ  = 2'd0,
        ADDR_RSP  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } rxq_addr_e;

    localparam int B_AVAIL = 8;   // + queue index
    localparam int B_ERR   = 10;  // + queue index
    localparam int B_LAST  = 12;  // + queue index
    localparam int B_SID   = 14;
    localparam int B_FULL  = 15;  // + queue index
    localparam int NQ      = 2;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_TOP = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t         ctl_q, ctl_d;
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];
    logic         push_ok, pop_ok;

    assign empty    = (ctl_q.cnt == '0);
    assign full     = (ctl_q.cnt == CNT_MAX);
    assign pop_data = mem_q[ctl_q.rp];

    always_comb begin
        ctl_d   = ctl_q;
        mem_d   = mem_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (flush) begin
            ctl_d = '0;
        end else begin
            if (push_ok) begin
                mem_d[ctl_q.wp] = push_data;
                ctl_d.wp = (ctl_q.wp == PTR_TOP) ? '0 : ctl_q.wp + 1'b1;
            end
            if (pop_ok) begin
                ctl_d.rp = (ctl_q.rp == PTR_TOP) ? '0 : ctl_q.rp + 1'b1;
            end
            if (push_ok && !pop_ok) ctl_d.cnt = ctl_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    AST_FIFO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_MAX); // R10
    AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full); // R10
endmodule

// File: rtl/rxq_lane.sv
module rxq_lane #(
    parameter int DW      = 32,
    parameter int DEPTH   = 8,
    parameter bit HAS_SID = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_last,
    input  logic          push_sid,
    input  logic          rd,
    input  logic          clr_err,
    input  logic          clr_full,
    output logic [DW-1:0] rd_data,
    output logic          avail,
    output logic          last,
    output logic          sid,
    output logic          err,
    output logic          full_flag
);
    localparam int EW = DW + 2;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          avail;
        logic          last;
        logic          sid;
        logic          err;
        logic          full;
        logic          win;
    } st_t;

    st_t           st_q, st_d;
    logic          sid_tag;
    logic [EW-1:0] head;
    logic          fifo_empty, fifo_full;
    logic          rd_ok, rd_bad, load;

    generate
        if (HAS_SID) begin : g_sid
            assign sid_tag = push_sid && st_q.win;
        end else begin : g_nosid
            assign sid_tag = 1'b0;
        end
    endgenerate

    assign rd_ok  = rd && !st_q.err && st_q.avail;
    assign rd_bad = rd && !st_q.err && !st_q.avail;
    assign load   = !st_q.avail && !fifo_empty && !bus_reset;

    rxq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (bus_reset),
        .push      (push),
        .push_data ({push_data, push_last, sid_tag}),
        .pop       (load),
        .pop_data  (head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    always_comb begin
        st_d = st_q;
        if (rd_ok) begin
            st_d.avail = 1'b0;
            st_d.last  = 1'b0;
            st_d.sid   = 1'b0;
        end
        if (load) begin
            st_d.data  = head[EW-1:2];
            st_d.last  = head[1];
            st_d.sid   = head[0];
            st_d.avail = 1'b1;
        end
        if (clr_err)   st_d.err  = 1'b0;
        if (rd_bad)    st_d.err  = 1'b1;
        if (clr_full)  st_d.full = 1'b0;
        if (fifo_full) st_d.full = 1'b1;
        if (push && !push_sid) st_d.win = 1'b0;
        if (bus_reset) begin
            st_d.avail = 1'b0;
            st_d.last  = 1'b0;
            st_d.sid   = 1'b0;
            st_d.err   = 1'b1;
            st_d.win   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.err <= 1'b1;
            st_q.win <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = rd_ok ? st_q.data : '0;
    assign avail     = st_q.avail;
    assign last      = st_q.last;
    assign sid       = st_q.sid;
    assign err       = st_q.err;
    assign full_flag = st_q.full;

    AST_RD_CLEARS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && avail && !err) |=> !avail); // R2
    AST_BLOCKED_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && err && avail && !bus_reset) |=> (avail && $stable(st_q.data))); // R5
    AST_BUS_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (err && !avail && !last && !sid)); // R7
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag && !clr_full) |=> full_flag); // R6
    AST_LAST_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> avail); // R3
endmodule

// File: rtl/rxq_xfer_port.sv
module rxq_xfer_port #(
    parameter int DW    = rxq_pkg::QW,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset,
    input  logic          req_push,
    input  logic [DW-1:0] req_data,
    input  logic          req_last,
    input  logic          req_sid,
    input  logic          rsp_push,
    input  logic [DW-1:0] rsp_data,
    input  logic          rsp_last,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata
);
    import rxq_pkg::*;

    logic          push_v [NQ];
    logic [DW-1:0] data_v [NQ];
    logic          last_in [NQ];
    logic          sid_in [NQ];
    logic          rd_v [NQ];
    logic          clr_err_v [NQ];
    logic          clr_full_v [NQ];
    logic [DW-1:0] rdat_v [NQ];
    logic          avail_v [NQ];
    logic          last_v [NQ];
    logic          sid_v [NQ];
    logic          err_v [NQ];
    logic          full_v [NQ];
    logic [DW-1:0] stat_w;
    logic          wr_stat;
    logic          unused_wdata_bits;

    assign push_v[0]  = req_push;
    assign data_v[0]  = req_data;
    assign last_in[0] = req_last;
    assign sid_in[0]  = req_sid;
    assign push_v[1]  = rsp_push;
    assign data_v[1]  = rsp_data;
    assign last_in[1] = rsp_last;
    assign sid_in[1]  = 1'b0;

    assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_STAT);

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_q
            assign rd_v[q]       = bus_sel && !bus_wr && (bus_addr == 2'(q));
            assign clr_err_v[q]  = wr_stat && bus_wdata[B_ERR + q];
            assign clr_full_v[q] = wr_stat && bus_wdata[B_FULL + q];

            rxq_lane #(.DW(DW), .DEPTH(DEPTH), .HAS_SID(q == 0)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .bus_reset (bus_reset),
                .push      (push_v[q]),
                .push_data (data_v[q]),
                .push_last (last_in[q]),
                .push_sid  (sid_in[q]),
                .rd        (rd_v[q]),
                .clr_err   (clr_err_v[q]),
                .clr_full  (clr_full_v[q]),
                .rd_data   (rdat_v[q]),
                .avail     (avail_v[q]),
                .last      (last_v[q]),
                .sid       (sid_v[q]),
                .err       (err_v[q]),
                .full_flag (full_v[q])
            );
        end
    endgenerate

    always_comb begin
        stat_w = '0;
        for (int q = 0; q < NQ; q++) begin
            stat_w[B_AVAIL + q] = avail_v[q];
            stat_w[B_ERR + q]   = err_v[q];
            stat_w[B_LAST + q]  = last_v[q];
            stat_w[B_FULL + q]  = full_v[q];
        end
        stat_w[B_SID] = sid_v[0] | sid_v[1];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_REQ:  bus_rdata = rdat_v[0];
                ADDR_RSP:  bus_rdata = rdat_v[1];
                ADDR_STAT: bus_rdata = stat_w;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign unused_wdata_bits = ^bus_wdata;

    AST_RSP_NO_SID: assert property (@(posedge clk) disable iff (!rst_n)
        !sid_v[1]); // R4
    AST_BUSRST_BLOCKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (err_v[0] && err_v[1])); // R7
endmodule

// File: tb/tb_rxq_xfer_port.sv
`timescale 1ns/1ps
module tb_rxq_xfer_port;
    localparam int DW = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_reset = 1'b0;
    logic          req_push = 1'b0, req_last = 1'b0, req_sid = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_push = 1'b0, rsp_last = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rxq_xfer_port #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .req_push(req_push), .req_data(req_data), .req_last(req_last), .req_sid(req_sid),
        .rsp_push(rsp_push), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // {data, last, sid, expected status while loaded}
    localparam int VN = 6;
    localparam logic [65:0] VEC [VN] = '{
        {32'hA5A50001, 1'b0, 1'b1, 32'h00004100},
        {32'h12345678, 1'b1, 1'b1, 32'h00005100},
        {32'hDEADBEEF, 1'b0, 1'b0, 32'h00000100},
        {32'h0BADF00D, 1'b0, 1'b1, 32'h00000100},
        {32'hCAFE0005, 1'b1, 1'b0, 32'h00001100},
        {32'h00000000, 1'b1, 1'b1, 32'h00001100}
    };

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] wd);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic push_req(input logic [DW-1:0] d, input logic l, input logic s);
        req_push = 1'b1; req_data = d; req_last = l; req_sid = s;
        @(negedge clk);
        req_push = 1'b0;
    endtask

    task automatic stat_is(input logic [DW-1:0] exp, input string tag);
        logic [DW-1:0] v;
        rd(2'd2, v);
        check(v, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        stat_is(32'h00000C00, "R8 reset value");
        rd(2'd0, v);
        check(v, 32'h0, "R5 blocked read returns 0");
        stat_is(32'h00000C00, "R5 blocked read leaves flags");
        wr(2'd2, 32'h0);
        stat_is(32'h00000C00, "R9 write zero no effect");
        wr(2'd2, 32'h00007300);
        stat_is(32'h00000C00, "R9 write to auto bits ignored");
        wr(2'd2, 32'h00000C00);
        stat_is(32'h00000000, "R9 write one clears errors");

        // Vector table: push, load, status, read, status
        for (int i = 0; i < VN; i++) begin
            push_req(VEC[i][65:34], VEC[i][33], VEC[i][32]);
            @(negedge clk);
            stat_is(VEC[i][31:0], "R3 R4 status while loaded");
            rd(2'd0, v);
            check(v, VEC[i][65:34], "R1 request quadlet");
            stat_is(32'h0, "R2 R3 flags clear after read");
        end

        // R5: read with nothing available
        rd(2'd0, v);
        check(v, 32'h0, "R5 empty read returns 0");
        stat_is(32'h00000400, "R5 empty read sets request error");
        wr(2'd2, 32'h00000400);

        // R2: refill one edge after read
        push_req(32'h00000011, 1'b0, 1'b0);
        push_req(32'h00000022, 1'b1, 1'b0);
        @(negedge clk);
        rd(2'd0, v);
        check(v, 32'h00000011, "R1 first of pair");
        stat_is(32'h00000000, "R2 available clear right after read");
        stat_is(32'h00001100, "R2 R3 next quadlet loaded");
        rd(2'd0, v);
        check(v, 32'h00000022, "R1 second of pair");

        // R10 / R6: fill response queue, tenth push dropped
        for (int i = 0; i < DEPTH + 2; i++) begin
            rsp_push = 1'b1; rsp_data = 32'h100 + i; rsp_last = (i == DEPTH);
            @(negedge clk);
        end
        rsp_push = 1'b0;
        @(negedge clk);
        stat_is(32'h00010200, "R6 response full flag set");
        for (int i = 0; i < DEPTH + 1; i++) begin
            rd(2'd1, v);
            check(v, 32'h100 + i, "R1 R10 response order");
            @(negedge clk);
        end
        stat_is(32'h00010000, "R10 extra push dropped, R6 full sticky");
        wr(2'd2, 32'h00008000);
        stat_is(32'h00010000, "R9 clearing other full bit no effect");
        wr(2'd2, 32'h00010000);
        stat_is(32'h00000000, "R6 full cleared by write one");

        // R7: bus reset flushes and blocks
        push_req(32'h00000077, 1'b0, 1'b0);
        push_req(32'h00000078, 1'b0, 1'b0);
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        stat_is(32'h00000C00, "R7 bus reset state");
        rd(2'd0, v);
        check(v, 32'h0, "R7 blocked after bus reset");
        wr(2'd2, 32'h00000C00);
        rd(2'd0, v);
        check(v, 32'h0, "R7 queued data flushed");
        stat_is(32'h00000400, "R7 flushed queue read errors");
        wr(2'd2, 32'h00000400);
        push_req(32'h5E1F0001, 1'b0, 1'b1);
        @(negedge clk);
        stat_is(32'h00004100, "R4 window reopened by bus reset");
        rd(2'd0, v);
        check(v, 32'h5E1F0001, "R4 self-ID quadlet data");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule